// File: doc/BRIEF.md
# Error-Correcting Word Store with Byte Merge

This block sits between a serial-memory protocol engine and a memory array that is 38 bits wide. Storage is organised in 4-byte units. Each unit holds 32 data bits and 6 Hamming check bits. The engine issues byte-addressed requests, and the block turns each one into accesses to the whole unit. A read fetches the unit, repairs any single flipped bit and returns the addressed byte. A write fetches the unit, repairs it, replaces the byte lanes that are enabled, recomputes the check bits and stores the full codeword again. Even a single-byte write therefore costs a full read-modify-write of the unit.

Every request runs the same four-cycle sequence: accept, array read, capture and correct, respond. The response cycle also carries the array write when the request is a write. The block accepts nothing else while a request is in flight. A one-cycle flag tells the engine that the fetched unit had a nonzero syndrome.

Top module: `eccstore_top`

## Requirements
- R1: The unit address driven on `arrAddr` is `reqAddr[ADDR_W-1:2]`. On a read, `reqAddr[1:0]` selects the returned byte, where lane n is data bits [8n+7:8n].
- R2: A codeword has data in bits [31:0] and check bits in [37:32]. The 38 code positions are numbered 1..38. Check bit k sits at position 2^k. Data bits 0..31 fill the remaining positions in ascending order, starting at position 3. Check bit k is the XOR of every data bit whose position has bit k set.
- R3: A single flipped data bit in the stored unit is corrected before any byte is returned or merged.
- R4: A single flipped check bit leaves the returned data unchanged.
- R5: A write replaces data lane n with `reqWData[8n+7:8n]` exactly when `reqByteEn[n]` is 1. It keeps the corrected old value in every other lane and drives the re-encoded codeword on `arrWrData` with `arrWrEn` high for exactly one cycle, in the response cycle, at the same unit address.
- R6: `reqReady` is high only when the block is idle. `arrRdEn` is high in the cycle after acceptance, and `respValid` is high for one cycle, two cycles after `arrRdEn`.
- R7: `corrErr` is high only in a response cycle, and only when the fetched unit had a nonzero syndrome.
- R8: A write with all byte enables low rewrites the corrected unit with clean check bits, so a later read of that unit reports no correction.
- R9: An erased unit (data FFFFFFFFh with matching check bits) reads FFh in every lane with `corrErr` low.
- R10: While `rstN` is low, `reqReady` is 1 and `respValid`, `arrRdEn`, `arrWrEn` and `corrErr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request taken this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address |
| reqWData | input | 32 | Write data, one byte per lane |
| reqByteEn | input | 4 | Lane enables for a write |
| respValid | output | 1 | Response cycle |
| respData | output | 8 | Byte returned by a read |
| corrErr | output | 1 | Nonzero syndrome seen on the fetched unit |
| arrAddr | output | ADDR_W-2 | Unit address to the array |
| arrRdEn | output | 1 | Array read strobe; data is expected one cycle later |
| arrRdData | input | 38 | Codeword from the array |
| arrWrEn | output | 1 | Array write strobe |
| arrWrData | output | 38 | Codeword to the array |

## Verification
The array model in the bench starts every unit at the erased codeword. Reads of untouched units therefore exercise the erased pattern. Writes with sparse, single-lane, empty and full lane masks separate a correct lane merge from one that overwrites or drops neighbouring lanes. A sweep flips each of the 38 codeword bits in turn under a fresh data pattern. This shows that every position maps to the right repair, and that a flipped check bit changes no data. A write into a unit that already holds a flipped bit shows that the merge uses the corrected value rather than the raw one.

// File: rtl/eccstore_pkg.sv
package eccstore_pkg;

  localparam int DATA_W = 32;
  localparam int CHK_W  = 6;
  localparam int CODE_W = DATA_W + CHK_W;
  localparam int LANES  = DATA_W / 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_CAPT,
    ST_DONE
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadWord;
  } ctrlT;

  // code position (1-based, powers of two skipped) of data bit idx
  function automatic logic [CHK_W-1:0] bitPos(input int idx);
    int seen;
    logic [CHK_W-1:0] pos;
    seen = 0;
    pos  = '0;
    for (int q = 3; q < (1 << CHK_W); q++) begin
      if ((q & (q - 1)) != 0) begin
        if (seen == idx) pos = CHK_W'(q);
        seen++;
      end
    end
    return pos;
  endfunction

  // check vector = XOR of the positions of all set data bits
  function automatic logic [CHK_W-1:0] calcCheck(input logic [DATA_W-1:0] d);
    logic [CHK_W-1:0] c;
    c = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (d[i]) c = c ^ bitPos(i);
    end
    return c;
  endfunction

  // flip the data bit whose position equals the syndrome
  function automatic logic [DATA_W-1:0] correctData(input logic [DATA_W-1:0] d,
                                                    input logic [CHK_W-1:0] syn);
    logic [DATA_W-1:0] f;
    f = d;
    for (int i = 0; i < DATA_W; i++) begin
      if (syn == bitPos(i)) f[i] = ~f[i];
    end
    return f;
  endfunction

endpackage

// File: rtl/eccstore_ctrl.sv
module eccstore_ctrl
  import eccstore_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic reqWrite,
  output logic reqReady,
  output ctrlT ctrl,
  output logic arrRdEn,
  output logic arrWrEn,
  output logic respValid
);

  stateT state;
  logic  isWriteQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      isWriteQ <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_ISSUE;
            isWriteQ <= reqWrite;
          end
        end
        ST_ISSUE: state <= ST_CAPT;
        ST_CAPT:  state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    reqReady      = (state == ST_IDLE);
    ctrl.loadReq  = reqReady && reqValid;
    ctrl.loadWord = (state == ST_CAPT);
    arrRdEn       = (state == ST_ISSUE);
    respValid     = (state == ST_DONE);
    arrWrEn       = (state == ST_DONE) && isWriteQ;
  end

endmodule

// File: rtl/eccstore_dp.sv
module eccstore_dp
  import eccstore_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWData,
  input  logic [LANES-1:0]  reqByteEn,
  input  logic [CODE_W-1:0] arrRdData,
  output logic [ADDR_W-3:0] arrAddr,
  output logic [CODE_W-1:0] arrWrData,
  output logic [7:0]        respData,
  output logic              corrFlag
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [LANES-1:0]  beQ;
  logic [DATA_W-1:0] wordQ;
  logic              corrQ;

  logic [DATA_W-1:0] rawData;
  logic [CHK_W-1:0]  rawChk;
  logic [CHK_W-1:0]  syndrome;
  logic [DATA_W-1:0] fixedData;
  logic [DATA_W-1:0] merged;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      wordQ  <= '0;
      corrQ  <= 1'b0;
    end else begin
      if (ctrl.loadReq) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWData;
        beQ    <= reqByteEn;
      end
      if (ctrl.loadWord) begin
        wordQ <= fixedData;
        corrQ <= (syndrome != '0);
      end
    end
  end

  always_comb begin
    rawData   = arrRdData[DATA_W-1:0];
    rawChk    = arrRdData[CODE_W-1:DATA_W];
    syndrome  = calcCheck(rawData) ^ rawChk;
    fixedData = correctData(rawData, syndrome);
  end

  for (genvar lane = 0; lane < LANES; lane++) begin : gMerge
    assign merged[8*lane +: 8] = beQ[lane] ? wdataQ[8*lane +: 8] : wordQ[8*lane +: 8];
  end

  assign arrAddr   = addrQ[ADDR_W-1:2];
  assign arrWrData = {calcCheck(merged), merged};
  assign respData  = wordQ[{addrQ[1:0], 3'b000} +: 8];
  assign corrFlag  = corrQ;

endmodule

// File: rtl/eccstore_top.sv
module eccstore_top
  import eccstore_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [31:0]       reqWData,
  input  logic [3:0]        reqByteEn,
  output logic              respValid,
  output logic [7:0]        respData,
  output logic              corrErr,
  output logic [ADDR_W-3:0] arrAddr,
  output logic              arrRdEn,
  input  logic [37:0]       arrRdData,
  output logic              arrWrEn,
  output logic [37:0]       arrWrData
);

  ctrlT ctrl;
  logic corrFlag;

  eccstore_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqReady  (reqReady),
    .ctrl      (ctrl),
    .arrRdEn   (arrRdEn),
    .arrWrEn   (arrWrEn),
    .respValid (respValid)
  );

  eccstore_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .reqAddr   (reqAddr),
    .reqWData  (reqWData),
    .reqByteEn (reqByteEn),
    .arrRdData (arrRdData),
    .arrAddr   (arrAddr),
    .arrWrData (arrWrData),
    .respData  (respData),
    .corrFlag  (corrFlag)
  );

  assign corrErr = respValid && corrFlag;

endmodule

// File: rtl/eccstore_chk.sv
module eccstore_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              arrRdEn,
  input logic              arrWrEn,
  input logic [ADDR_W-3:0] arrAddr,
  input logic              respValid,
  input logic              corrErr
);

  AST_READ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> arrRdEn); // R6

  AST_RESP_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    arrRdEn |=> ##1 respValid); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    (arrRdEn || respValid) |-> !reqReady); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!arrRdEn && !arrWrEn)); // R6

  AST_WRITE_IN_RESP: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> respValid); // R5

  AST_WRITE_SAME_UNIT: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> arrAddr == $past(arrAddr, 2)); // R5

  AST_CORR_IN_RESP: assert property (@(posedge clk) disable iff (!rstN)
    corrErr |-> respValid); // R7

  AST_CORR_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    corrErr |=> !corrErr); // R7

endmodule

bind eccstore_top eccstore_chk #(.ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .arrRdEn   (arrRdEn),
  .arrWrEn   (arrWrEn),
  .arrAddr   (arrAddr),
  .respValid (respValid),
  .corrErr   (corrErr)
);

// File: tb/sim_eccstore_top.sv
module sim_eccstore_top;

  localparam int AW    = 8;
  localparam int UNITS = 1 << (AW - 2);
  localparam int WDOG  = 150000;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqReady;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [31:0]   reqWData = '0;
  logic [3:0]    reqByteEn = '0;
  logic          respValid;
  logic [7:0]    respData;
  logic          corrErr;
  logic [AW-3:0] arrAddr;
  logic          arrRdEn;
  logic [37:0]   arrRdData;
  logic          arrWrEn;
  logic [37:0]   arrWrData;

  always #10 clk = ~clk;

  eccstore_top #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWData(reqWData),
    .reqByteEn(reqByteEn), .respValid(respValid), .respData(respData),
    .corrErr(corrErr), .arrAddr(arrAddr), .arrRdEn(arrRdEn),
    .arrRdData(arrRdData), .arrWrEn(arrWrEn), .arrWrData(arrWrData)
  );

  // independent encoder from the R2 definition
  function automatic logic [37:0] refEncode(input logic [31:0] d);
    logic [5:0] c;
    int p;
    c = '0;
    p = 2;
    for (int i = 0; i < 32; i++) begin
      p++;
      while ((p & (p - 1)) == 0) p++;
      for (int k = 0; k < 6; k++) begin
        if (d[i] && p[k]) c[k] = ~c[k];
      end
    end
    return {c, d};
  endfunction

  // array model with synchronous read and bit-flip injection
  logic [37:0]   mem [UNITS];
  logic [37:0]   rdQ;
  logic          injReq = 1'b0;
  logic [AW-3:0] injUnit = '0;
  logic [5:0]    injBit = '0;

  always @(posedge clk) begin
    if (!rstN) begin
      for (int u = 0; u < UNITS; u++) mem[u] <= refEncode(32'hFFFF_FFFF);
      rdQ <= '0;
    end else begin
      if (arrRdEn) rdQ <= mem[arrAddr];
      if (arrWrEn) mem[arrAddr] <= arrWrData;
      if (injReq) mem[injUnit][injBit] <= ~mem[injUnit][injBit];
    end
  end
  assign arrRdData = rdQ;

  // reference model state and expected responses
  logic [31:0] refData [UNITS];
  bit          dirty [UNITS];
  int          qCyc[$];
  bit          qWr[$];
  bit          qCorr[$];
  logic [31:0] qWord[$];
  logic [7:0]  qByte[$];
  logic [AW-3:0] qUnit[$];
  string       qTag[$];

  int  cyc = 0;
  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // monitor: compares the design against the model on every clock
  always @(negedge clk) begin
    if (!rstN) begin
      check(reqReady === 1'b1, "R10", 64'(reqReady), 64'd1);
      check({respValid, arrRdEn, arrWrEn, corrErr} === 4'b0000, "R10",
            64'({respValid, arrRdEn, arrWrEn, corrErr}), 64'd0);
    end else begin
      automatic bit busy = (qCyc.size() > 0) && (cyc >= qCyc[0] - 2);
      automatic bit due  = (qCyc.size() > 0) && (cyc == qCyc[0]);
      check(reqReady === !busy, "R6", 64'(reqReady), 64'(!busy));
      check(respValid === due, "R6", 64'(respValid), 64'(due));
      if (due) begin
        automatic bit          eWr   = qWr.pop_front();
        automatic bit          eCorr = qCorr.pop_front();
        automatic logic [31:0] eWord = qWord.pop_front();
        automatic logic [7:0]  eByte = qByte.pop_front();
        automatic logic [AW-3:0] eUnit = qUnit.pop_front();
        automatic string       eTag  = qTag.pop_front();
        void'(qCyc.pop_front());
        check(corrErr === eCorr, "R7", 64'(corrErr), 64'(eCorr));
        check(arrWrEn === eWr, "R5", 64'(arrWrEn), 64'(eWr));
        if (eWr) begin
          check(arrWrData === refEncode(eWord), "R2", 64'(arrWrData), 64'(refEncode(eWord)));
          check(arrWrData[31:0] === eWord, eTag, 64'(arrWrData[31:0]), 64'(eWord));
          check(arrAddr === eUnit, "R1", 64'(arrAddr), 64'(eUnit));
        end else begin
          check(respData === eByte, eTag, 64'(respData), 64'(eByte));
        end
      end else begin
        check(corrErr === 1'b0, "R7", 64'(corrErr), 64'd0);
        check(arrWrEn === 1'b0, "R5", 64'(arrWrEn), 64'd0);
      end
    end
    if (cyc >= WDOG) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected below %0d", cyc, WDOG);
      done = 1'b1;
    end
    if (done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic doReq(input bit wr, input logic [AW-1:0] a, input logic [31:0] wd,
                       input logic [3:0] be, input string tag);
    logic [AW-3:0] u;
    logic [31:0]   m;
    @(negedge clk);
    reqValid  = 1'b1;
    reqWrite  = wr;
    reqAddr   = a;
    reqWData  = wd;
    reqByteEn = be;
    while (!reqReady) @(negedge clk);
    u = a[AW-1:2];
    m = refData[u];
    if (wr) begin
      for (int l = 0; l < 4; l++) if (be[l]) m[8*l +: 8] = wd[8*l +: 8];
    end
    qCyc.push_back(cyc + 3);
    qWr.push_back(wr);
    qCorr.push_back(dirty[u]);
    qWord.push_back(m);
    qByte.push_back(refData[u][8*a[1:0] +: 8]);
    qUnit.push_back(u);
    qTag.push_back(tag);
    if (wr) begin
      refData[u] = m;
      dirty[u]   = 1'b0;
    end
    @(negedge clk);
    reqValid = 1'b0;
    while (qCyc.size() != 0) @(negedge clk);
  endtask

  task automatic flipBit(input logic [AW-3:0] u, input int b);
    @(negedge clk);
    injUnit = u;
    injBit  = 6'(b);
    injReq  = 1'b1;
    dirty[u] = 1'b1;
    @(negedge clk);
    injReq = 1'b0;
  endtask

  initial begin
    for (int u = 0; u < UNITS; u++) begin
      refData[u] = 32'hFFFF_FFFF;
      dirty[u]   = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R9: erased unit reads FFh in every lane
    for (int l = 0; l < 4; l++) doReq(1'b0, AW'(5 * 4 + l), '0, '0, "R9");

    // R5: sparse lane merge, then R1 lane selection
    doReq(1'b1, AW'(12), 32'h1122_3344, 4'b0101, "R5");
    for (int l = 0; l < 4; l++) doReq(1'b0, AW'(12 + l), '0, '0, "R1");

    // R3: data bit flipped, corrected on every read
    flipBit(6'd3, 17);
    doReq(1'b0, AW'(14), '0, '0, "R3");
    doReq(1'b0, AW'(13), '0, '0, "R3");

    // R4: check bit flipped, data unchanged
    flipBit(6'd7, 34);
    doReq(1'b0, AW'(28), '0, '0, "R4");
    doReq(1'b0, AW'(31), '0, '0, "R4");

    // R5 / R3: merge uses the corrected word
    doReq(1'b1, AW'(13), 32'hAABB_CCDD, 4'b0010, "R5");
    doReq(1'b0, AW'(13), '0, '0, "R3");
    doReq(1'b0, AW'(14), '0, '0, "R3");

    // R8: empty lane mask scrubs the unit
    doReq(1'b1, AW'(28), 32'h0, 4'b0000, "R8");
    doReq(1'b0, AW'(29), '0, '0, "R8");

    // R3 / R4: every codeword bit position, fresh pattern each time
    for (int b = 0; b < 38; b++) begin
      doReq(1'b1, AW'(40), (32'(b) * 32'h0101_0101) ^ 32'h5A3C_96E1, 4'b1111, "R5");
      flipBit(6'd10, b);
      doReq(1'b0, AW'(40 + (b % 4)), '0, '0, (b < 32) ? "R3" : "R4");
    end

    // R1: highest unit, top lane only
    doReq(1'b1, AW'(255), 32'h7E00_0000, 4'b1000, "R5");
    doReq(1'b0, AW'(255), '0, '0, "R1");
    doReq(1'b0, AW'(252), '0, '0, "R1");

    repeat (3) @(negedge clk);
    done = 1'b1;
  end

endmodule